// File: doc/BRIEF.md
# Power-Mode and System-Clock Controller

This block chooses how a small processor core is clocked and which oscillators stay alive. It holds an 8-bit clock control byte that software writes through a simple write strobe. Its inputs are four oscillator tick inputs: a high-speed RC tick, a high-speed crystal tick, a low-speed RC tick and a low-speed crystal tick. Each tick input is a one-cycle clock enable at the block's reference clock. The block turns these into one CPU clock enable. In the full-speed run mode the enable is the chosen high-speed tick divided by a power of two from 1 to 64. In the reduced-speed run mode the enable follows the chosen subclock tick.

A halt request moves the core into one of four low-power states. The state is picked by two idle-enable bits in the control byte, and it fixes which of the high-speed and subclock oscillators are kept gated on for peripherals. A wake event brings the core back to the run mode named by the clock select field. The return happens on the first tick of that mode's clock. A 3-bit mode output reports the current state.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode output is 0 (full-speed run mode). The divide ratio is 1 and the high-speed source is the RC tick, so `cpuClkEn` follows `hircTick`. `hsGate` is 1 and `lsGate` is 0.
- R2: Control bits 7:5 hold a select code. Codes 0 to 6 give full-speed run mode (mode 0). In that mode `cpuClkEn` pulses once for every 2^code high-speed ticks, and the count starts from the write that entered the mode.
- R3: Select code 7 gives reduced-speed run mode (mode 1). In that mode `cpuClkEn` equals the selected subclock tick, `hsGate` is 0 and `lsGate` is 1.
- R4: Control bit 3 picks the high-speed tick: 1 selects `hxtTick` and 0 selects `hircTick`. Control bit 2 picks the subclock tick: 1 selects `lxtTick` and 0 selects `lircTick`.
- R5: A halt in a run mode with bit 1 = 0 and bit 0 = 0 gives mode 2. In mode 2 `cpuClkEn` is 0 and both gates are 0; the low-speed RC that serves the watchdog runs outside this block.
- R6: A halt with bit 1 = 0 and bit 0 = 1 gives mode 3. In mode 3 `cpuClkEn` is 0, `hsGate` is 0 and `lsGate` is 1.
- R7: A halt with bit 1 = 1 and bit 0 = 1 gives mode 4. In mode 4 `cpuClkEn` is 0 and both gates are 1.
- R8: A halt with bit 1 = 1 and bit 0 = 0 gives mode 5. In mode 5 `cpuClkEn` is 0, `hsGate` is 1 and `lsGate` is 0.
- R9: A wake pulse in any low-power state is remembered. The block returns to run mode (mode 0 or 1, chosen by the select code) at the first clock edge where the tick of that run mode's clock is high. Until then the mode does not change.
- R10: A select change written while in mode 0 takes effect only at the divider's terminal count. Pulses already counting under the old ratio are never shortened.
- R11: When a halt and a control write fall in the same cycle, the low-power state is decoded from the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| hircTick | input | 1 | High-speed RC oscillator tick |
| hxtTick | input | 1 | High-speed crystal oscillator tick |
| lircTick | input | 1 | Low-speed RC oscillator tick |
| lxtTick | input | 1 | Low-speed crystal oscillator tick |
| haltReq | input | 1 | Halt request from the core (one cycle) |
| wake | input | 1 | Wake event from interrupt or watchdog |
| cfgWe | input | 1 | Control byte write strobe |
| cfgWdata | input | 8 | Control byte write data |
| cpuClkEn | output | 1 | CPU clock enable |
| hsGate | output | 1 | Keep selected high-speed oscillator running |
| lsGate | output | 1 | Keep selected subclock oscillator running |
| modeOut | output | 3 | Current mode code (0 to 5) |

## Verification
Two events can fall in the same cycle, and the bench drives both cases. In the first, a control write and a halt request arrive together: the byte changes the idle-enable bits, and the new state must follow the written bits, not the old ones. In the second, a ratio write arrives in full-speed mode partway through a divide period: the next pulse must come at the old terminal count, and the pulses after it at the new rate. The bench judges this by the exact cycle index of each pulse.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int SEL_W       = 3;
  localparam int CNT_W       = (1 << SEL_W) - 2;
  localparam int CTRL_W      = 8;
  localparam int SEL_LSB     = 5;
  localparam int RSVD_BIT    = 4;
  localparam int HS_SRC_BIT  = 3;
  localparam int SUB_SRC_BIT = 2;
  localparam int HS_IDLE_BIT = 1;
  localparam int LS_IDLE_BIT = 0;
  localparam logic [SEL_W-1:0] SLOW_CODE = '1;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_SLOW   = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_IDLE0  = 3'd3,
    MODE_IDLE1  = 3'd4,
    MODE_IDLE2  = 3'd5
  } pwrMode_t;

  typedef struct packed {
    logic runNormal;
    logic runSlow;
  } clkStb_t;

  function automatic logic [CNT_W-1:0] divTerm(input logic [SEL_W-1:0] sel);
    logic [31:0] full;
    full = (32'd1 << sel) - 32'd1;
    divTerm = full[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/pmc_clk_path.sv
module pmc_clk_path
  import pmc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CTRL_W-1:0]   cfgWdata,
  input  clkStb_t             stb,
  input  logic                hircTick,
  input  logic                hxtTick,
  input  logic                lircTick,
  input  logic                lxtTick,
  output logic                hsTick,
  output logic                subTick,
  output logic [SEL_W-1:0]    effSel,
  output logic                effHsIdle,
  output logic                effLsIdle,
  output logic                cpuClkEn
);

  logic [SEL_W-1:0] selQ;
  logic             hsSrcQ;
  logic             subSrcQ;
  logic             hsIdleQ;
  logic             lsIdleQ;
  logic             unusedRsvd;

  logic [CNT_W-1:0] divCnt;
  logic [SEL_W-1:0] activeSel;
  logic             atTerm;

  assign unusedRsvd = cfgWdata[RSVD_BIT];

  // control byte storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= '0;
      hsSrcQ  <= 1'b0;
      subSrcQ <= 1'b0;
      hsIdleQ <= 1'b0;
      lsIdleQ <= 1'b0;
    end else if (cfgWe) begin
      selQ    <= cfgWdata[SEL_LSB +: SEL_W];
      hsSrcQ  <= cfgWdata[HS_SRC_BIT];
      subSrcQ <= cfgWdata[SUB_SRC_BIT];
      hsIdleQ <= cfgWdata[HS_IDLE_BIT];
      lsIdleQ <= cfgWdata[LS_IDLE_BIT];
    end
  end

  // effective view: a write in this cycle already counts
  assign effSel    = cfgWe ? cfgWdata[SEL_LSB +: SEL_W] : selQ;
  assign effHsIdle = cfgWe ? cfgWdata[HS_IDLE_BIT] : hsIdleQ;
  assign effLsIdle = cfgWe ? cfgWdata[LS_IDLE_BIT] : lsIdleQ;

  // oscillator source selection
  assign hsTick  = hsSrcQ  ? hxtTick : hircTick;
  assign subTick = subSrcQ ? lxtTick : lircTick;

  // power-of-two divider with ratio swap only at terminal count
  assign atTerm = (divCnt == divTerm(activeSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      activeSel <= '0;
    end else if (!stb.runNormal) begin
      divCnt <= '0;
      if (effSel != SLOW_CODE) activeSel <= effSel;
    end else if (hsTick) begin
      if (atTerm) begin
        divCnt <= '0;
        if (effSel != SLOW_CODE) activeSel <= effSel;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign cpuClkEn = (stb.runNormal & hsTick & atTerm) | (stb.runSlow & subTick);

  // ratio must not move in the middle of a divide period
  p_ratio_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.runNormal && !(hsTick && atTerm)) |=> $stable(activeSel));

  // the counter never runs past the terminal count of the active ratio
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.runNormal && hsTick && !atTerm) |=> (divCnt != '0));

endmodule

// File: rtl/pmc_mode_ctl.sv
module pmc_mode_ctl
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             wake,
  input  logic [SEL_W-1:0] effSel,
  input  logic             effHsIdle,
  input  logic             effLsIdle,
  input  logic             hsTick,
  input  logic             subTick,
  output pwrMode_t         modeQ,
  output clkStb_t          stb,
  output logic             hsGate,
  output logic             lsGate
);

  pwrMode_t modeNext;
  pwrMode_t runTarget;
  pwrMode_t haltTarget;
  logic     isRun;
  logic     targetTick;
  logic     wakePend;
  logic     wakeAny;

  assign isRun      = (modeQ == MODE_NORMAL) || (modeQ == MODE_SLOW);
  assign runTarget  = (effSel == SLOW_CODE) ? MODE_SLOW : MODE_NORMAL;
  assign targetTick = (effSel == SLOW_CODE) ? subTick : hsTick;
  assign wakeAny    = wake | wakePend;

  always_comb begin
    unique case ({effHsIdle, effLsIdle})
      2'b00:   haltTarget = MODE_SLEEP;
      2'b01:   haltTarget = MODE_IDLE0;
      2'b11:   haltTarget = MODE_IDLE1;
      default: haltTarget = MODE_IDLE2;
    endcase
  end

  always_comb begin
    modeNext = modeQ;
    if (isRun) begin
      modeNext = haltReq ? haltTarget : runTarget;
    end else if (wakeAny && targetTick) begin
      modeNext = runTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_NORMAL;
      wakePend <= 1'b0;
    end else begin
      modeQ <= modeNext;
      if (isRun || (wakeAny && targetTick)) wakePend <= 1'b0;
      else if (wake)                        wakePend <= 1'b1;
    end
  end

  always_comb begin
    hsGate = 1'b0;
    lsGate = 1'b0;
    unique case (modeQ)
      MODE_NORMAL: hsGate = 1'b1;
      MODE_SLOW:   lsGate = 1'b1;
      MODE_IDLE0:  lsGate = 1'b1;
      MODE_IDLE1:  begin hsGate = 1'b1; lsGate = 1'b1; end
      MODE_IDLE2:  hsGate = 1'b1;
      default:     ;
    endcase
  end

  assign stb.runNormal = (modeQ == MODE_NORMAL);
  assign stb.runSlow   = (modeQ == MODE_SLOW);

  p_halt_leaves_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && haltReq) |=> !isRun);

  p_sleep_decode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && haltReq && !effHsIdle && !effLsIdle) |=> (modeQ == MODE_SLEEP));

  p_idle0_decode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && haltReq && !effHsIdle && effLsIdle) |=> (modeQ == MODE_IDLE0));

  p_idle1_decode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && haltReq && effHsIdle && effLsIdle) |=> (modeQ == MODE_IDLE1));

  p_idle2_decode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && haltReq && effHsIdle && !effLsIdle) |=> (modeQ == MODE_IDLE2));

  p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!isRun && !wakeAny) |=> $stable(modeQ));

  p_wake_needs_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!isRun && !targetTick) |=> $stable(modeQ));

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hircTick,
  input  logic              hxtTick,
  input  logic              lircTick,
  input  logic              lxtTick,
  input  logic              haltReq,
  input  logic              wake,
  input  logic              cfgWe,
  input  logic [CTRL_W-1:0] cfgWdata,
  output logic              cpuClkEn,
  output logic              hsGate,
  output logic              lsGate,
  output logic [2:0]        modeOut
);

  clkStb_t          stb;
  pwrMode_t         modeQ;
  logic             hsTick;
  logic             subTick;
  logic [SEL_W-1:0] effSel;
  logic             effHsIdle;
  logic             effLsIdle;

  pmc_clk_path uPath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .stb       (stb),
    .hircTick  (hircTick),
    .hxtTick   (hxtTick),
    .lircTick  (lircTick),
    .lxtTick   (lxtTick),
    .hsTick    (hsTick),
    .subTick   (subTick),
    .effSel    (effSel),
    .effHsIdle (effHsIdle),
    .effLsIdle (effLsIdle),
    .cpuClkEn  (cpuClkEn)
  );

  pmc_mode_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .haltReq   (haltReq),
    .wake      (wake),
    .effSel    (effSel),
    .effHsIdle (effHsIdle),
    .effLsIdle (effLsIdle),
    .hsTick    (hsTick),
    .subTick   (subTick),
    .modeQ     (modeQ),
    .stb       (stb),
    .hsGate    (hsGate),
    .lsGate    (lsGate)
  );

  assign modeOut = modeQ;

  p_low_no_cpu_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_NORMAL && modeQ != MODE_SLOW) |-> !cpuClkEn);

  p_slow_tracks_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLOW) |-> (cpuClkEn == subTick));

  p_normal_needs_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NORMAL && !hsTick) |-> !cpuClkEn);

endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;

  localparam int PERIOD = 10;
  localparam int NVEC   = 9;

  // vector table: control byte, ticking source (0 hirc,1 hxt,2 lirc,3 lxt),
  // tick period, expected pulses in 128 cycles, expected mode
  localparam logic [7:0] V_CFG  [NVEC] = '{8'h00, 8'h28, 8'h40, 8'h68, 8'h80, 8'hA8, 8'hC0, 8'hE4, 8'hE0};
  localparam int         V_SRC  [NVEC] = '{0, 1, 0, 1, 0, 1, 0, 3, 2};
  localparam int         V_PER  [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 4, 2};
  localparam int         V_EXP  [NVEC] = '{128, 64, 32, 16, 8, 4, 2, 32, 64};
  localparam int         V_MODE [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hircTick = 1'b0, hxtTick = 1'b0, lircTick = 1'b0, lxtTick = 1'b0;
  logic       haltReq = 1'b0, wake = 1'b0, cfgWe = 1'b0;
  logic [7:0] cfgWdata = 8'h00;
  logic       cpuClkEn, hsGate, lsGate;
  logic [2:0] modeOut;

  int checks = 0;
  int errors = 0;

  pmc_top dut (
    .clk(clk), .rstN(rstN),
    .hircTick(hircTick), .hxtTick(hxtTick), .lircTick(lircTick), .lxtTick(lxtTick),
    .haltReq(haltReq), .wake(wake), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cpuClkEn(cpuClkEn), .hsGate(hsGate), .lsGate(lsGate), .modeOut(modeOut)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic setTicks(input logic h, input logic x, input logic l, input logic lx);
    hircTick = h; hxtTick = x; lircTick = l; lxtTick = lx;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWe = 1'b1; cfgWdata = v;
    cyc();
    cfgWe = 1'b0;
  endtask

  task automatic halt();
    haltReq = 1'b1;
    cyc();
    haltReq = 1'b0;
  endtask

  // low-power entry and wake through the high-speed RC tick
  task automatic lowPowerCase(input string req, input logic [7:0] cfg, input int expMode,
                              input int expHs, input int expLs);
    setTicks(0, 0, 0, 0);
    writeCfg(cfg);
    halt();
    setTicks(1, 0, 0, 0);
    #1;
    check(req, "mode after halt", modeOut, expMode);
    check(req, "hsGate", hsGate, expHs);
    check(req, "lsGate", lsGate, expLs);
    check(req, "cpuClkEn stopped", cpuClkEn, 0);
    cyc();
    check("R9", "no wake keeps low power", modeOut, expMode);
    setTicks(0, 0, 0, 0);
    wake = 1'b1;
    cyc();
    wake = 1'b0;
    check("R9", "wake without tick waits", modeOut, expMode);
    cyc();
    check("R9", "pending wake still waits", modeOut, expMode);
    setTicks(1, 0, 0, 0);
    cyc();
    check("R9", "wake returns to run", modeOut, 0);
    setTicks(0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    setTicks(1, 0, 0, 0);
    #1;
    check("R1", "reset mode", modeOut, 0);
    check("R1", "reset hsGate", hsGate, 1);
    check("R1", "reset lsGate", lsGate, 0);
    check("R1", "divide by one follows hirc", cpuClkEn, 1);
    setTicks(0, 0, 0, 0);
    #1;
    check("R1", "no tick no enable", cpuClkEn, 0);
    cyc();

    // R2 R3 R4 vector table
    for (int v = 0; v < NVEC; v++) begin
      int pulses;
      setTicks(0, 0, 0, 0);
      writeCfg(8'hE0);
      writeCfg(V_CFG[v]);
      pulses = 0;
      for (int i = 0; i < 128; i++) begin
        logic t;
        t = ((i % V_PER[v]) == 0);
        setTicks(V_SRC[v] == 0 ? t : 1'b0, V_SRC[v] == 1 ? t : 1'b0,
                 V_SRC[v] == 2 ? t : 1'b0, V_SRC[v] == 3 ? t : 1'b0);
        #1;
        if (cpuClkEn) pulses++;
        cyc();
      end
      check(V_MODE[v] == 0 ? "R2" : "R3", $sformatf("pulse count vec%0d", v), pulses, V_EXP[v]);
      check("R3", $sformatf("mode vec%0d", v), modeOut, V_MODE[v]);
      check("R3", $sformatf("hsGate vec%0d", v), hsGate, V_MODE[v] == 0 ? 1 : 0);
      check("R3", $sformatf("lsGate vec%0d", v), lsGate, V_MODE[v] == 1 ? 1 : 0);
    end

    // R4 wrong source gives no enable
    begin
      int pulses = 0;
      setTicks(0, 0, 0, 0);
      writeCfg(8'h08);
      for (int i = 0; i < 8; i++) begin
        setTicks(1, 0, 1, 1);
        #1;
        if (cpuClkEn) pulses++;
        cyc();
      end
      check("R4", "crystal selected, RC ignored", pulses, 0);
      setTicks(0, 0, 0, 0);
      writeCfg(8'hE0);
      pulses = 0;
      for (int i = 0; i < 8; i++) begin
        setTicks(1, 1, 0, 1);
        #1;
        if (cpuClkEn) pulses++;
        cyc();
      end
      check("R4", "subclock RC selected, crystal ignored", pulses, 0);
    end

    // R10 ratio change mid period
    begin
      int first = -1;
      int pulses = 0;
      setTicks(0, 0, 0, 0);
      writeCfg(8'hE0);
      writeCfg(8'h60);
      for (int i = 0; i < 20; i++) begin
        setTicks(1, 0, 0, 0);
        if (i == 2) begin cfgWe = 1'b1; cfgWdata = 8'h00; end
        #1;
        if (cpuClkEn) begin
          pulses++;
          if (first < 0) first = i;
        end
        cyc();
        cfgWe = 1'b0;
      end
      check("R10", "first pulse at old terminal count", first, 7);
      check("R10", "pulses after swap", pulses, 13);
    end

    // R5..R8 low-power decode and R9 wake
    lowPowerCase("R5", 8'h00, 2, 0, 0);
    lowPowerCase("R6", 8'h01, 3, 0, 1);
    lowPowerCase("R7", 8'h03, 4, 1, 1);
    lowPowerCase("R8", 8'h02, 5, 1, 0);

    // R9 wake into reduced-speed mode waits for subclock tick
    setTicks(0, 0, 0, 0);
    writeCfg(8'hE1);
    halt();
    check("R6", "idle0 from slow", modeOut, 3);
    wake = 1'b1;
    setTicks(1, 0, 0, 0);
    cyc();
    wake = 1'b0;
    check("R9", "high-speed tick does not wake slow target", modeOut, 3);
    setTicks(0, 0, 1, 0);
    cyc();
    check("R9", "subclock tick wakes to slow", modeOut, 1);
    setTicks(0, 0, 0, 0);

    // R11 write and halt in the same cycle
    writeCfg(8'h00);
    cyc();
    cfgWe = 1'b1; cfgWdata = 8'h03; haltReq = 1'b1;
    cyc();
    cfgWe = 1'b0; haltReq = 1'b0;
    check("R11", "state from written byte", modeOut, 4);
    check("R11", "hsGate from written byte", hsGate, 1);
    check("R11", "lsGate from written byte", lsGate, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule